// File: doc/BRIEF.md
# Coincidence Trigger Decision Unit

This unit makes the final accept decision for one reconstructed event at a time. Each event arrives as a single-cycle strobe. With it come a photon energy sum, an azimuth code for the photon and one for the positron, two arrival times and a flag saying whether the positron counter was hit. Five cuts are evaluated against programmable settings:

- the energy threshold;
- the photon azimuth range;
- the positron hit;
- the time coincidence window;
- the photon–positron azimuth match window.

An event that passes every cut gives a normal trigger.

Debug triggers let the cuts themselves be studied. Each debug mode has a mask that names the cuts it ignores, clipped to at most two cuts. An event that fails the full selection but passes the relaxed one is a candidate for that mode. A prescaler then picks every Nth candidate. A second prescaler marks every Nth normal trigger as a request for full waveform readout. Every trigger, normal or debug, requests a status readout.

Times are 16-bit values in sixteenths of a 10 ns period, so the nominal coincidence window is 160. The decision is registered. It appears exactly two clock cycles after the input strobe is sampled, as a valid pulse with a 3-bit type code.

Top module: `coinc_trig_top`

## Requirements
- R1: The energy cut (cut bit 0) passes only when `gam_energy` is strictly greater than `cfg_e_thr`.
- R2: The photon range cut (cut bit 1) passes when `cfg_phi_lo <= gam_phi <= cfg_phi_hi`, both bounds inclusive.
- R3: The positron hit cut (cut bit 2) passes only when `pos_hit` is 1.
- R4: The time cut (cut bit 3) passes when `|gam_time - pos_time| <= cfg_dt_win`, in either order of arrival.
- R5: The direction match cut (cut bit 4) passes when `|gam_phi - pos_phi| <= cfg_dphi_win`, taking the codes as unsigned numbers.
- R6: An event that passes all five cuts produces `trig_valid` = 1 with `trig_type[0]` = 1. This appears in the cycle two clock edges after `in_valid` is sampled, and not one edge after.
- R7: `trig_type[2]` (waveform readout) is set on every Nth normal trigger since reset, where N = `cfg_wf_pre`. With N = 0 it is never set, and it never appears without `trig_type[0]`.
- R8: Debug mode k uses mask `cfg_dbg_mask[5k+4:5k]` and prescale `cfg_dbg_pre[8k+7:8k]`. An event that fails the full selection but passes with the masked cuts ignored is a candidate. Every Nth candidate of that mode sets `trig_valid` and `trig_type[1]`. N = 0 disables the mode, and a normal event is never a candidate.
- R9: A debug mask with more than two bits set acts as only its two lowest set bits.
- R10: `rd_status` equals `trig_valid` on every trigger. When there is no trigger, `trig_valid`, `trig_type` and `rd_status` are all 0, and `trig_type[0]` and `trig_type[1]` are never both 1.
- R11: Synchronous reset clears the outputs and all prescale counters, so counting restarts from the first event after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle event strobe |
| gam_energy | input | 16 | Photon energy sum |
| gam_phi | input | 8 | Photon azimuth code |
| pos_phi | input | 8 | Positron azimuth code |
| gam_time | input | 16 | Photon arrival time, 1/16 of 10 ns |
| pos_time | input | 16 | Positron arrival time, 1/16 of 10 ns |
| pos_hit | input | 1 | Positron counter hit flag |
| cfg_e_thr | input | 16 | Energy threshold |
| cfg_phi_lo | input | 8 | Lowest accepted photon azimuth code |
| cfg_phi_hi | input | 8 | Highest accepted photon azimuth code |
| cfg_dphi_win | input | 8 | Azimuth match window |
| cfg_dt_win | input | 16 | Time coincidence window |
| cfg_wf_pre | input | 8 | Waveform readout prescale, 0 disables |
| cfg_dbg_mask | input | 10 | Two 5-bit ignored-cut masks, mode 0 in the low bits |
| cfg_dbg_pre | input | 16 | Two 8-bit debug prescales, mode 0 in the low byte |
| trig_valid | output | 1 | Trigger issued |
| trig_type | output | 3 | bit0 normal, bit1 debug, bit2 waveform readout |
| rd_status | output | 1 | Status readout request |

## Verification
The assertions assume that the configuration inputs hold steady while an event is in flight. They also assume `in_valid` is low before reset is released, so a two-cycle look back never sees an event from before reset. The bench changes configuration only between events and pulses reset after each change. It drives one event at a time with idle cycles in between, so both assumptions hold. Random events keep the positron azimuth and time close to the photon's, so every cut is exercised on both sides.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int NCUT     = 5;
  localparam int CUT_ENE  = 0;
  localparam int CUT_RNG  = 1;
  localparam int CUT_HIT  = 2;
  localparam int CUT_TIME = 3;
  localparam int CUT_DIR  = 4;
  localparam int TYPE_W   = 3;

  typedef logic [NCUT-1:0] cut_vec_t;

  // keep the two least significant set bits of a mask
  function automatic cut_vec_t clip_two(input cut_vec_t m);
    cut_vec_t first, rest, second;
    first  = m & (~m + cut_vec_t'(1));
    rest   = m & ~first;
    second = rest & (~rest + cut_vec_t'(1));
    return first | second;
  endfunction
endpackage

// File: rtl/ct_cut_eval.sv
module ct_cut_eval
  import ct_pkg::*;
#(
  parameter int EW = 16,
  parameter int PW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [EW-1:0] gam_energy,
  input  logic [PW-1:0] gam_phi,
  input  logic [PW-1:0] pos_phi,
  input  logic [TW-1:0] gam_time,
  input  logic [TW-1:0] pos_time,
  input  logic          pos_hit,
  input  logic [EW-1:0] cfg_e_thr,
  input  logic [PW-1:0] cfg_phi_lo,
  input  logic [PW-1:0] cfg_phi_hi,
  input  logic [PW-1:0] cfg_dphi_win,
  input  logic [TW-1:0] cfg_dt_win,
  output logic          s1_valid,
  output cut_vec_t      s1_cuts
);
  logic [TW-1:0] dt_abs;
  logic [PW-1:0] dphi_abs;
  cut_vec_t      cuts;

  always_comb begin
    dt_abs   = (gam_time >= pos_time) ? gam_time - pos_time : pos_time - gam_time;
    dphi_abs = (gam_phi >= pos_phi) ? gam_phi - pos_phi : pos_phi - gam_phi;
    cuts           = '0;
    cuts[CUT_ENE]  = gam_energy > cfg_e_thr;
    cuts[CUT_RNG]  = (gam_phi >= cfg_phi_lo) && (gam_phi <= cfg_phi_hi);
    cuts[CUT_HIT]  = pos_hit;
    cuts[CUT_TIME] = dt_abs <= cfg_dt_win;
    cuts[CUT_DIR]  = dphi_abs <= cfg_dphi_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_cuts  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_cuts  <= in_valid ? cuts : '0;
    end
  end

  // R1
  ene_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gam_energy <= cfg_e_thr) |=> !s1_cuts[CUT_ENE]);
  // R3
  hit_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pos_hit) |=> !s1_cuts[CUT_HIT]);
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PSW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hit,
  input  logic [PSW-1:0] n,
  output logic           fire
);
  logic [PSW-1:0] cnt;
  logic [PSW:0]   nxt;

  assign nxt  = {1'b0, cnt} + (PSW+1)'(1);
  assign fire = hit && (n != '0) && (nxt >= {1'b0, n});

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (hit && n != '0)
      cnt <= fire ? '0 : nxt[PSW-1:0];
  end

  // R7
  pre_off_chk: assert property (@(posedge clk) disable iff (rst)
    (n == '0) |-> !fire);
endmodule

// File: rtl/coinc_trig_top.sv
module coinc_trig_top
  import ct_pkg::*;
#(
  parameter int EW   = 16,
  parameter int PW   = 8,
  parameter int TW   = 16,
  parameter int PSW  = 8,
  parameter int NDBG = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [EW-1:0]        gam_energy,
  input  logic [PW-1:0]        gam_phi,
  input  logic [PW-1:0]        pos_phi,
  input  logic [TW-1:0]        gam_time,
  input  logic [TW-1:0]        pos_time,
  input  logic                 pos_hit,
  input  logic [EW-1:0]        cfg_e_thr,
  input  logic [PW-1:0]        cfg_phi_lo,
  input  logic [PW-1:0]        cfg_phi_hi,
  input  logic [PW-1:0]        cfg_dphi_win,
  input  logic [TW-1:0]        cfg_dt_win,
  input  logic [PSW-1:0]       cfg_wf_pre,
  input  logic [NDBG*NCUT-1:0] cfg_dbg_mask,
  input  logic [NDBG*PSW-1:0]  cfg_dbg_pre,
  output logic                 trig_valid,
  output logic [TYPE_W-1:0]    trig_type,
  output logic                 rd_status
);
  logic            s1_valid;
  cut_vec_t        s1_cuts;
  logic            norm;
  logic            wf_fire;
  logic [NDBG-1:0] dcand;
  logic [NDBG-1:0] dfire;

  ct_cut_eval #(.EW(EW), .PW(PW), .TW(TW)) u_cuts (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .gam_energy(gam_energy), .gam_phi(gam_phi), .pos_phi(pos_phi),
    .gam_time(gam_time), .pos_time(pos_time), .pos_hit(pos_hit),
    .cfg_e_thr(cfg_e_thr), .cfg_phi_lo(cfg_phi_lo), .cfg_phi_hi(cfg_phi_hi),
    .cfg_dphi_win(cfg_dphi_win), .cfg_dt_win(cfg_dt_win),
    .s1_valid(s1_valid), .s1_cuts(s1_cuts)
  );

  assign norm = s1_valid && (&s1_cuts);

  ct_prescaler #(.PSW(PSW)) u_wf_pre (
    .clk(clk), .rst(rst), .hit(norm), .n(cfg_wf_pre), .fire(wf_fire)
  );

  for (genvar k = 0; k < NDBG; k++) begin : g_dbg
    cut_vec_t relax;
    assign relax    = clip_two(cfg_dbg_mask[k*NCUT +: NCUT]);
    assign dcand[k] = s1_valid && !norm && (&(s1_cuts | relax));
    ct_prescaler #(.PSW(PSW)) u_dbg_pre (
      .clk(clk), .rst(rst), .hit(dcand[k]),
      .n(cfg_dbg_pre[k*PSW +: PSW]), .fire(dfire[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_valid <= 1'b0;
      trig_type  <= '0;
      rd_status  <= 1'b0;
    end else begin
      trig_valid <= norm || (|dfire);
      rd_status  <= norm || (|dfire);
      trig_type  <= {norm && wf_fire, |dfire, norm};
    end
  end

  // R6
  lat_two_chk: assert property (@(posedge clk) disable iff (rst)
    trig_valid |-> $past(in_valid, 2));
  // R10
  type_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_type[1:0]));
  // R7
  wave_norm_chk: assert property (@(posedge clk) disable iff (rst)
    trig_type[2] |-> trig_type[0]);
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !trig_valid |-> (trig_type == '0 && !rd_status));
endmodule

// File: tb/tb_coinc_trig_top.sv
module tb_coinc_trig_top;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [15:0] gam_energy = 0;
  logic [7:0]  gam_phi = 0, pos_phi = 0;
  logic [15:0] gam_time = 0, pos_time = 0;
  logic        pos_hit = 0;
  logic [15:0] cfg_e_thr = 450;
  logic [7:0]  cfg_phi_lo = 16, cfg_phi_hi = 240, cfg_dphi_win = 6;
  logic [15:0] cfg_dt_win = 160;
  logic [7:0]  cfg_wf_pre = 0;
  logic [9:0]  cfg_dbg_mask = 0;
  logic [15:0] cfg_dbg_pre = 0;
  logic        trig_valid, rd_status;
  logic [2:0]  trig_type;

  int n_chk = 0, n_fail = 0;
  int cw = 0, cd0 = 0, cd1 = 0;
  bit done = 0;

  always #10 clk = ~clk;

  coinc_trig_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .gam_energy(gam_energy), .gam_phi(gam_phi), .pos_phi(pos_phi),
    .gam_time(gam_time), .pos_time(pos_time), .pos_hit(pos_hit),
    .cfg_e_thr(cfg_e_thr), .cfg_phi_lo(cfg_phi_lo), .cfg_phi_hi(cfg_phi_hi),
    .cfg_dphi_win(cfg_dphi_win), .cfg_dt_win(cfg_dt_win),
    .cfg_wf_pre(cfg_wf_pre), .cfg_dbg_mask(cfg_dbg_mask), .cfg_dbg_pre(cfg_dbg_pre),
    .trig_valid(trig_valid), .trig_type(trig_type), .rd_status(rd_status)
  );

  function automatic [4:0] b_clip(input [4:0] m);
    int got = 0;
    b_clip = 0;
    for (int i = 0; i < 5; i++)
      if (m[i] && got < 2) begin b_clip[i] = 1'b1; got++; end
  endfunction

  function automatic [4:0] b_cuts(input int e, gp, pp, gt, pt, input bit h);
    int dt = (gt > pt) ? gt - pt : pt - gt;
    int dp = (gp > pp) ? gp - pp : pp - gp;
    b_cuts[0] = e > int'(cfg_e_thr);
    b_cuts[1] = gp >= int'(cfg_phi_lo) && gp <= int'(cfg_phi_hi);
    b_cuts[2] = h;
    b_cuts[3] = dt <= int'(cfg_dt_win);
    b_cuts[4] = dp <= int'(cfg_dphi_win);
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,type,status} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    cw = 0; cd0 = 0; cd1 = 0;
  endtask

  task automatic send(input string tag, input int e, gp, pp, gt, pt, input bit h);
    logic [4:0] c;
    bit norm, wf, dbg;
    int pre;
    c = b_cuts(e, gp, pp, gt, pt, h);
    norm = &c; wf = 0; dbg = 0;
    if (norm && cfg_wf_pre != 0) begin
      cw++; if (cw == cfg_wf_pre) begin wf = 1; cw = 0; end
    end
    if (!norm && (&(c | b_clip(cfg_dbg_mask[4:0]))) && cfg_dbg_pre[7:0] != 0) begin
      cd0++; if (cd0 == cfg_dbg_pre[7:0]) begin dbg = 1; cd0 = 0; end
    end
    pre = cfg_dbg_pre[15:8];
    if (!norm && (&(c | b_clip(cfg_dbg_mask[9:5]))) && pre != 0) begin
      cd1++; if (cd1 == pre) begin dbg = 1; cd1 = 0; end
    end
    gam_energy = 16'(e); gam_phi = 8'(gp); pos_phi = 8'(pp);
    gam_time = 16'(gt); pos_time = 16'(pt); pos_hit = h; in_valid = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check({tag, " R6 latency"}, {trig_valid, trig_type, rd_status}, 5'b0);
    @(posedge clk); @(negedge clk);
    check(tag, {trig_valid, trig_type, rd_status},
          {norm || dbg, wf, dbg, norm, norm || dbg});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset", {trig_valid, trig_type, rd_status}, 5'b0);
    rst = 0;

    send("R6 good", 600, 100, 103, 1000, 1100, 1);
    send("R1 eq thr", 450, 100, 103, 1000, 1100, 1);
    send("R1 above", 451, 100, 103, 1000, 1100, 1);
    send("R2 lo", 600, 16, 16, 1000, 1000, 1);
    send("R2 below", 600, 15, 15, 1000, 1000, 1);
    send("R2 hi", 600, 240, 240, 1000, 1000, 1);
    send("R2 above", 600, 241, 241, 1000, 1000, 1);
    send("R3 nohit", 600, 100, 100, 1000, 1000, 0);
    send("R4 edge", 600, 100, 100, 1000, 1160, 1);
    send("R4 out", 600, 100, 100, 1000, 1161, 1);
    send("R4 rev edge", 600, 100, 100, 1160, 1000, 1);
    send("R4 rev out", 600, 100, 100, 1161, 1000, 1);
    send("R5 edge", 600, 100, 106, 1000, 1000, 1);
    send("R5 out", 600, 100, 107, 1000, 1000, 1);
    send("R5 neg edge", 600, 100, 94, 1000, 1000, 1);
    send("R5 neg out", 600, 100, 93, 1000, 1000, 1);
    check("R10 idle", {trig_valid, trig_type, rd_status}, 5'b0);

    cfg_wf_pre = 3; do_reset();
    for (int i = 0; i < 6; i++) send("R7 every 3rd", 600, 100, 100, 1000, 1000, 1);
    cfg_wf_pre = 1; do_reset();
    for (int i = 0; i < 2; i++) send("R7 every", 600, 100, 100, 1000, 1000, 1);
    cfg_wf_pre = 0; do_reset();
    send("R7 off", 600, 100, 100, 1000, 1000, 1);

    cfg_dbg_mask = 10'b00000_01000; cfg_dbg_pre = 16'h0002; do_reset();
    send("R8 cand 1", 600, 100, 100, 1000, 2000, 1);
    send("R8 normal", 600, 100, 100, 1000, 1000, 1);
    send("R8 not cand", 400, 100, 100, 1000, 1000, 1);
    send("R8 cand 2", 600, 100, 100, 1000, 2000, 1);

    cfg_dbg_mask = 10'b01010_00000; cfg_dbg_pre = 16'h0000; do_reset();
    send("R8 pre0", 600, 100, 100, 1000, 2000, 1);
    cfg_dbg_mask = 10'b11010_00000; cfg_dbg_pre = 16'h0100; do_reset();
    send("R9 dir clipped", 600, 100, 120, 1000, 1000, 1);
    send("R9 time kept", 600, 100, 100, 1000, 2000, 1);
    send("R9 range kept", 600, 250, 250, 1000, 1000, 1);

    cfg_dbg_mask = 0; cfg_dbg_pre = 0; cfg_wf_pre = 2; do_reset();
    send("R11 pre", 600, 100, 100, 1000, 1000, 1);
    do_reset();
    send("R11 restart 1", 600, 100, 100, 1000, 1000, 1);
    send("R11 restart 2", 600, 100, 100, 1000, 1000, 1);

    cfg_wf_pre = 3; cfg_dbg_mask = 10'b10111_01000; cfg_dbg_pre = 16'h0102;
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int gp = int'($urandom_range(0, 255));
      int pp = gp + int'($urandom_range(0, 20)) - 10;
      int gt = int'($urandom_range(1000, 30000));
      int pt = gt + int'($urandom_range(0, 400)) - 200;
      if (pp < 0) pp = 0;
      if (pp > 255) pp = 255;
      send("R6 random", int'($urandom_range(300, 700)), gp, pp, gt, pt,
           $urandom_range(0, 9) != 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule